// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards a 32-bit memory-mapped register file against stray writes. It watches a simple register bus and, on each write, says in the same cycle whether the write may land in the register file (`wr_allow`) or must be dropped (`wr_deny`). The register file itself stays outside the block and only uses `wr_allow` as its write strobe.

Two lock registers sit in the same address space. The first one sits at word offset 0x00 and the second at byte offset 0x7C, which is word 31. All accesses are aligned 32-bit words. While the block is unlocked, any write to either lock register engages the lock. Releasing it takes two steps. First, a second magic value is written to the second lock register. Then the first magic value is written to the first lock register. A correct release clears both lock registers.

The block reads as locked when the first lock register holds exactly 1. Software can read that register. Reads of the second lock register always return zero. Reset leaves the block unlocked.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the block is unlocked (`locked` = 0), and a read of word 0 returns 0.
- R2: While unlocked, a write of any value to word 0 or word 31 locks the block from the next cycle. It also clears the stored second key.
- R3: While unlocked, a write to any word other than 0 and 31 raises `wr_allow` in that same cycle, and `wr_deny` stays low.
- R4: While locked, a write to any word other than 0 and 31 raises `wr_deny` for that cycle, and `wr_allow` stays low.
- R5: While locked, a write to word 31 stores the written value unchanged. A later write overwrites an earlier one. A read of word 31 always returns 0.
- R6: While locked, writing 0xC0DEFA73 to word 0 unlocks the block from the next cycle, but only when word 31 currently holds 0xC0DE1248. The release clears both lock registers.
- R7: While locked, a write to word 0 with any other value, or with word 31 holding anything other than 0xC0DE1248, leaves the block locked.
- R8: With `rd_en` high at word 0, `rd_data` carries the lock state in bit 0 and zeros in bits 31:1. In every other case `rd_data` is 0.
- R9: A write to word 0 or word 31 never raises `wr_allow` or `wr_deny`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wr_data | input | DATA_W | Write data |
| locked | output | 1 | High while writes to protected words are blocked |
| wr_allow | output | 1 | Write may update the protected register file this cycle |
| wr_deny | output | 1 | Write to a protected word was discarded this cycle |
| rd_data | output | DATA_W | Read data for the lock registers |

## Verification
The assertions assume three things about the bus:
- A write lasts exactly one cycle.
- The address and data are stable around the clock edge.
- `wr_en` and `rd_en` are never unknown after reset.

The bench meets these assumptions by changing every input on the falling clock edge and returning the strobes low between accesses. The comparisons that depend on the unlock state look at `locked` one cycle after the write, because that is when the registered state can first have changed. The stimulus covers three address classes: word 0, word 31, and an ordinary word. It drives the right magic values, near-miss values, and a stale or overwritten second key.

// File: rtl/reg_write_guard.sv
module reg_write_guard #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int KEY1_WORD = 0,
  parameter int KEY2_WORD = 31,
  parameter logic [DATA_W-1:0] OPEN_CODE = 32'hC0DEFA73,
  parameter logic [DATA_W-1:0] ARM_CODE  = 32'hC0DE1248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked,
  output logic              wr_allow,
  output logic              wr_deny,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] K1_ADDR = ADDR_W'(KEY1_WORD);
  localparam logic [ADDR_W-1:0] K2_ADDR = ADDR_W'(KEY2_WORD);

  logic              lock_q;
  logic [DATA_W-1:0] arm_q;

  wire hit_k1   = (addr == K1_ADDR);
  wire hit_k2   = (addr == K2_ADDR);
  wire hit_lock = hit_k1 | hit_k2;
  wire release_ok = lock_q && wr_en && hit_k1 && (wr_data == OPEN_CODE) && (arm_q == ARM_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      arm_q  <= '0;
    end else if (wr_en && hit_lock) begin
      if (!lock_q) begin
        lock_q <= 1'b1;
        arm_q  <= '0;
      end else if (hit_k2) begin
        arm_q <= wr_data;
      end else if (release_ok) begin
        lock_q <= 1'b0;
        arm_q  <= '0;
      end
    end
  end

  assign locked   = lock_q;
  assign wr_allow = wr_en & ~hit_lock & ~lock_q;
  assign wr_deny  = wr_en & ~hit_lock &  lock_q;
  assign rd_data  = (rd_en && hit_k1) ? DATA_W'(lock_q) : '0;

  a_r2_lock_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en && hit_lock) |=> locked);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |=> (!locked && arm_q == '0));

  a_r7_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !release_ok) |=> locked);

  a_r5_arm_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && hit_k2) |=> (arm_q == $past(wr_data)));

  a_r4_deny_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |-> (locked && !wr_allow));

  a_r9_lock_words_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_lock) |-> (!wr_allow && !wr_deny));

  a_r8_read_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || hit_k2) |-> (rd_data == '0));

  a_r3_allow_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> (!locked && wr_en));

endmodule

// File: tb/reg_write_guard_tb_top.sv
module reg_write_guard_tb_top;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam logic [AW-1:0] W0  = 10'd0;
  localparam logic [AW-1:0] W31 = 10'd31;
  localparam logic [AW-1:0] WX  = 10'd5;
  localparam logic [DW-1:0] OPEN = 32'hC0DEFA73;
  localparam logic [DW-1:0] ARM  = 32'hC0DE1248;

  typedef struct packed {
    logic [3:0]    req;
    logic          we;
    logic          re;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic          lk;
    logic          al;
    logic          dn;
    logic [DW-1:0] rd;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd8, 1'b0, 1'b1, W0,  32'h0,        1'b0, 1'b0, 1'b0, 32'h0}, // R8 read word 0 unlocked
    '{4'd3, 1'b1, 1'b0, WX,  32'hDEAD0001, 1'b0, 1'b1, 1'b0, 32'h0}, // R3 ordinary write allowed
    '{4'd5, 1'b0, 1'b1, W31, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0}, // R5 word 31 reads 0
    '{4'd2, 1'b1, 1'b0, W31, 32'h00001234, 1'b1, 1'b0, 1'b0, 32'h0}, // R2 lock via word 31
    '{4'd8, 1'b0, 1'b1, W0,  32'h0,        1'b1, 1'b0, 1'b0, 32'h1}, // R8 lock bit visible
    '{4'd4, 1'b1, 1'b0, WX,  32'h0BADBEEF, 1'b1, 1'b0, 1'b1, 32'h0}, // R4 denied while locked
    '{4'd7, 1'b1, 1'b0, W0,  OPEN,         1'b1, 1'b0, 1'b0, 32'h0}, // R7 word 31 not armed
    '{4'd9, 1'b1, 1'b0, W31, ARM,          1'b1, 1'b0, 1'b0, 32'h0}, // R9 arm, no allow/deny
    '{4'd5, 1'b0, 1'b1, W31, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0}, // R5 armed word 31 reads 0
    '{4'd7, 1'b1, 1'b0, W0,  32'hC0DEFA74, 1'b1, 1'b0, 1'b0, 32'h0}, // R7 near-miss value
    '{4'd8, 1'b0, 1'b0, W0,  32'h0,        1'b1, 1'b0, 1'b0, 32'h0}, // R8 no rd_en -> 0
    '{4'd6, 1'b1, 1'b0, W0,  OPEN,         1'b0, 1'b0, 1'b0, 32'h0}, // R6 release
    '{4'd1, 1'b0, 1'b1, W0,  32'h0,        1'b0, 1'b0, 1'b0, 32'h0}, // R1 reads back unlocked
    '{4'd2, 1'b1, 1'b0, W0,  32'h0,        1'b1, 1'b0, 1'b0, 32'h0}, // R2 lock via word 0
    '{4'd6, 1'b1, 1'b0, W0,  OPEN,         1'b1, 1'b0, 1'b0, 32'h0}, // R6 arm cleared by release
    '{4'd5, 1'b1, 1'b0, W31, ARM,          1'b1, 1'b0, 1'b0, 32'h0}, // R5 store arm
    '{4'd5, 1'b1, 1'b0, W31, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0}, // R5 overwrite arm
    '{4'd5, 1'b1, 1'b0, W0,  OPEN,         1'b1, 1'b0, 1'b0, 32'h0}, // R5 latest value wins
    '{4'd6, 1'b1, 1'b0, W31, ARM,          1'b1, 1'b0, 1'b0, 32'h0}, // R6 re-arm
    '{4'd6, 1'b1, 1'b0, W0,  OPEN,         1'b0, 1'b0, 1'b0, 32'h0}, // R6 release again
    '{4'd3, 1'b1, 1'b0, WX,  32'h1,        1'b0, 1'b1, 1'b0, 32'h0}  // R3 allowed after release
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          locked, wr_allow, wr_deny;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  reg_write_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .locked(locked), .wr_allow(wr_allow),
    .wr_deny(wr_deny), .rd_data(rd_data)
  );

  task automatic chk(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    wr_en = v.we; rd_en = v.re; addr = v.a; wr_data = v.wd;
    #2;
    chk(v.req, "wr_allow", DW'(wr_allow), DW'(v.al));
    chk(v.req, "wr_deny",  DW'(wr_deny),  DW'(v.dn));
    chk(v.req, "rd_data",  rd_data,       v.rd);
    @(posedge clk);
    #2;
    chk(v.req, "locked",   DW'(locked),   DW'(v.lk));
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(1, "locked after reset", DW'(locked), 32'h0);
    rd_en = 1'b1; addr = W0;
    #1;
    chk(1, "rd word 0 after reset", rd_data, 32'h0);
    rd_en = 1'b0;

    for (int i = 0; i < NV; i++) access(VEC[i]);

    access('{4'd2, 1'b1, 1'b0, W31, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 32'h0});
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    chk(1, "reset while locked", DW'(locked), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access('{4'd1, 1'b1, 1'b0, WX, 32'h7, 1'b0, 1'b1, 1'b0, 32'h0});
    access('{4'd6, 1'b1, 1'b0, W0, OPEN, 1'b1, 1'b0, 1'b0, 32'h0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule